// File: doc/BRIEF.md
# Speculative Retirement Buffer

This block keeps the program order of a speculative out-of-order core. Every issued instruction takes the entry at the tail of a circular buffer, and the block hands back that entry's index as the instruction's tag. The block records whether the instruction is a branch and which architectural register it targets. Execution units later place each result on a shared result bus together with the tag. The matching entry stores the value and becomes ready. While a result waits in the buffer, issue logic can read it by tag through a set of read ports.

Entries retire strictly from the head, one per cycle, once the head entry is ready. A retiring ordinary instruction writes its value to the architectural register file. A retiring branch that was predicted correctly just frees its entry. A retiring branch that was mispredicted empties the whole buffer and produces a one-cycle redirect to the correct target. For a branch, the bus value carries that target and a separate bus flag marks the misprediction.

Top module: `spec_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `arf_we` and `redirect_valid` are 0, and every read port reports not ready.
- R2: Each accepted allocation takes the tail entry and returns its index on `alloc_tag` in the same cycle. Successive tags count up by one and wrap from DEPTH-1 to 0.
- R3: When all DEPTH entries are occupied, `alloc_ready` is 0 and an `alloc_valid` is ignored. No entry is created, and the tail does not move.
- R4: A bus write (`cdb_valid`) whose tag names an occupied entry stores `cdb_value` and `cdb_mispredict` there and marks the entry ready. From the next cycle, a read port given that tag shows ready=1 and the value.
- R5: Entries retire in allocation order only. An entry whose result arrived early is not written to the register file before all older entries have retired.
- R6: A head entry that is not a branch retires on the clock edge after it becomes ready. In the following cycle, `arf_we`=1, `arf_addr` is its destination and `arf_data` is its value. At most one entry retires per cycle.
- R7: A retiring branch with `mispredict`=0 frees its entry, does not write the register file and does not redirect.
- R8: A retiring branch with `mispredict`=1 empties every entry. The following cycle carries a single-cycle `redirect_valid` pulse, with `redirect_target` equal to the branch's bus value. Younger entries never retire, and the next allocation receives tag 0.
- R9: An allocation and a retirement may take place in the same cycle. Both take effect, so occupancy stays the same.
- R10: A bus write whose tag names an unoccupied entry has no effect. An entry allocated later at that index reads as not ready.
- R11: A read port given the tag of an occupied entry whose result has not arrived reports ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Issue requests an entry |
| alloc_is_branch | input | 1 | Instruction class: 1 = branch, 0 = register-writing op |
| alloc_dest | input | 5 | Destination architectural register |
| alloc_ready | output | 1 | Tail entry free; allocation accepted this cycle |
| alloc_tag | output | 3 | Tag of the entry an allocation takes |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 3 | Entry the result belongs to |
| cdb_value | input | 32 | Result value, or correct target for a branch |
| cdb_mispredict | input | 1 | Branch was mispredicted |
| rd_tag | input | 6 | Read-port tags, port i at bits [3i+2:3i] |
| rd_ready | output | 2 | Per port: addressed entry holds a result |
| rd_value | output | 64 | Per port value, port i at bits [32i+31:32i] |
| arf_we | output | 1 | Register-file write strobe (registered) |
| arf_addr | output | 5 | Register-file write address |
| arf_data | output | 32 | Register-file write data |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_target | output | 32 | Fetch restart address |

## Verification
The bench builds the block at its default parameters: 8 entries, 3-bit tags and two read ports. With 8 entries, a short directed run can fill the buffer to its limit, make the tail wrap past index 7, and retire across that wrap. Because there are two ports, one port can be compared with another that names a different entry in the same cycle. The sequences line up a mispredicted branch behind a pending older entry and in front of an already finished younger one. This shows that the flush discards completed work and that retirement waits for the oldest entry.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int SRB_DATA_W = 32;
  localparam int SRB_REG_W  = 5;

  typedef enum logic {
    OPC_REGWRITE = 1'b0,
    OPC_BRANCH   = 1'b1
  } op_class_e;
endpackage

// File: rtl/srb_ptrs.sv
module srb_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= bump(tail);
      if (retire_fire) head <= bump(head);
      case ({alloc_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r2_gap_matches_count: assert property (@(posedge clk) disable iff (rst)
    ((int'(tail) + DEPTH - int'(head)) % DEPTH) == (int'(count) % DEPTH));
endmodule

// File: rtl/srb_store.sv
module srb_store
  import srb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = SRB_DATA_W,
  parameter int REG_W  = SRB_REG_W,
  parameter int NUM_RD = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    alloc_fire,
  input  logic [TAG_W-1:0]        tail,
  input  op_class_e               alloc_cls,
  input  logic [REG_W-1:0]        alloc_dest,
  input  logic                    retire_fire,
  input  logic [TAG_W-1:0]        head,
  input  logic                    cdb_valid,
  input  logic [TAG_W-1:0]        cdb_tag,
  input  logic [DATA_W-1:0]       cdb_value,
  input  logic                    cdb_mispredict,
  input  logic [NUM_RD*TAG_W-1:0] rd_tag,
  output logic [NUM_RD-1:0]       rd_ready,
  output logic [NUM_RD*DATA_W-1:0] rd_value,
  output logic                    tail_busy,
  output logic                    head_busy,
  output logic                    head_rdy,
  output op_class_e               head_cls,
  output logic                    head_mis,
  output logic [REG_W-1:0]        head_dest,
  output logic [DATA_W-1:0]       head_value
);
  logic              busy_q [DEPTH];
  logic              rdy_q  [DEPTH];
  logic              mis_q  [DEPTH];
  op_class_e         cls_q  [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  logic cdb_hit;
  assign cdb_hit = cdb_valid && busy_q[cdb_tag] && !flush;

  // control flags carry the reset and the flush
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        busy_q[i] <= 1'b0;
        rdy_q[i]  <= 1'b0;
        mis_q[i]  <= 1'b0;
      end
    end else begin
      if (retire_fire) busy_q[head] <= 1'b0;
      if (alloc_fire) begin
        busy_q[tail] <= 1'b1;
        rdy_q[tail]  <= 1'b0;
        mis_q[tail]  <= 1'b0;
      end
      if (cdb_hit) begin
        rdy_q[cdb_tag] <= 1'b1;
        mis_q[cdb_tag] <= cdb_mispredict;
      end
    end
  end

  // payload fields have no reset and a single write port each
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      cls_q[tail] <= alloc_cls;
      dst_q[tail] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (cdb_hit) val_q[cdb_tag] <= cdb_value;
  end

  generate
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [TAG_W-1:0] t;
      assign t = rd_tag[p*TAG_W +: TAG_W];
      assign rd_ready[p] = busy_q[t] && rdy_q[t];
      assign rd_value[p*DATA_W +: DATA_W] = val_q[t];
    end
  endgenerate

  assign tail_busy  = busy_q[tail];
  assign head_busy  = busy_q[head];
  assign head_rdy   = rdy_q[head];
  assign head_cls   = cls_q[head];
  assign head_mis   = mis_q[head];
  assign head_dest  = dst_q[head];
  assign head_value = val_q[head];

  a_r2_alloc_marks_pending: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !flush) |=> (busy_q[$past(tail)] && !rdy_q[$past(tail)]));

  a_r4_capture_sets_ready: assert property (@(posedge clk) disable iff (rst)
    (cdb_hit && !retire_fire) |=> rdy_q[$past(cdb_tag)]);
endmodule

// File: rtl/srb_retire.sv
module srb_retire
  import srb_pkg::*;
#(
  parameter int DATA_W = SRB_DATA_W,
  parameter int REG_W  = SRB_REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_busy,
  input  logic              head_rdy,
  input  op_class_e         head_cls,
  input  logic              head_mis,
  input  logic [REG_W-1:0]  head_dest,
  input  logic [DATA_W-1:0] head_value,
  output logic              retire_fire,
  output logic              flush,
  output logic              arf_we,
  output logic [REG_W-1:0]  arf_addr,
  output logic [DATA_W-1:0] arf_data,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_target
);
  logic is_br;
  assign is_br       = (head_cls == OPC_BRANCH);
  assign retire_fire = head_busy && head_rdy;
  assign flush       = retire_fire && is_br && head_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      arf_we          <= 1'b0;
      arf_addr        <= '0;
      arf_data        <= '0;
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
    end else begin
      arf_we         <= retire_fire && !is_br;
      redirect_valid <= flush;
      if (retire_fire && !is_br) begin
        arf_addr <= head_dest;
        arf_data <= head_value;
      end
      if (flush) redirect_target <= head_value;
    end
  end

  a_r8_redirect_single: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);

  a_r7_no_write_with_redirect: assert property (@(posedge clk) disable iff (rst)
    !(arf_we && redirect_valid));
endmodule

// File: rtl/spec_retire_buf.sv
module spec_retire_buf
  import srb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = SRB_DATA_W,
  parameter int REG_W  = SRB_REG_W,
  parameter int NUM_RD = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic                     alloc_is_branch,
  input  logic [REG_W-1:0]         alloc_dest,
  output logic                     alloc_ready,
  output logic [TAG_W-1:0]         alloc_tag,
  input  logic                     cdb_valid,
  input  logic [TAG_W-1:0]         cdb_tag,
  input  logic [DATA_W-1:0]        cdb_value,
  input  logic                     cdb_mispredict,
  input  logic [NUM_RD*TAG_W-1:0]  rd_tag,
  output logic [NUM_RD-1:0]        rd_ready,
  output logic [NUM_RD*DATA_W-1:0] rd_value,
  output logic                     arf_we,
  output logic [REG_W-1:0]         arf_addr,
  output logic [DATA_W-1:0]        arf_data,
  output logic                     redirect_valid,
  output logic [DATA_W-1:0]        redirect_target
);
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              alloc_fire, retire_fire, flush, tail_busy;
  logic              head_busy, head_rdy, head_mis;
  op_class_e         head_cls, alloc_cls;
  logic [REG_W-1:0]  head_dest;
  logic [DATA_W-1:0] head_value;

  assign alloc_cls   = alloc_is_branch ? OPC_BRANCH : OPC_REGWRITE;
  assign alloc_ready = !tail_busy && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail;

  srb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .retire_fire(retire_fire),
    .flush(flush), .head(head), .tail(tail), .count(count)
  );

  srb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .NUM_RD(NUM_RD)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_fire(alloc_fire), .tail(tail), .alloc_cls(alloc_cls), .alloc_dest(alloc_dest),
    .retire_fire(retire_fire), .head(head),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_mispredict(cdb_mispredict),
    .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_value(rd_value),
    .tail_busy(tail_busy), .head_busy(head_busy), .head_rdy(head_rdy),
    .head_cls(head_cls), .head_mis(head_mis), .head_dest(head_dest),
    .head_value(head_value)
  );

  srb_retire #(.DATA_W(DATA_W), .REG_W(REG_W)) u_retire (
    .clk(clk), .rst(rst), .head_busy(head_busy), .head_rdy(head_rdy),
    .head_cls(head_cls), .head_mis(head_mis), .head_dest(head_dest),
    .head_value(head_value), .retire_fire(retire_fire), .flush(flush),
    .arf_we(arf_we), .arf_addr(arf_addr), .arf_data(arf_data),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target)
  );

  a_r3_full_blocks_alloc: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);

  a_r8_empty_after_flush: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (count == '0));

  a_r9_occupancy_kept: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && retire_fire && !flush) |=> (count == $past(count)));
endmodule

// File: tb/spec_retire_buf_tb_top.sv
`timescale 1ns/1ps
module spec_retire_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 1'b0, alloc_is_branch = 1'b0;
  logic [4:0]  alloc_dest = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cdb_valid = 1'b0, cdb_mispredict = 1'b0;
  logic [2:0]  cdb_tag = '0;
  logic [31:0] cdb_value = '0;
  logic [5:0]  rd_tag = '0;
  logic [1:0]  rd_ready;
  logic [63:0] rd_value;
  logic        arf_we, redirect_valid;
  logic [4:0]  arf_addr;
  logic [31:0] arf_data, redirect_target;

  int checks = 0, errors = 0;
  int nlog = 0, nred = 0;
  logic [4:0]  log_addr [64];
  logic [31:0] log_data [64];
  logic [31:0] last_tgt;

  always #4 clk = ~clk;

  spec_retire_buf dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_is_branch(alloc_is_branch),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_mispredict(cdb_mispredict), .rd_tag(rd_tag), .rd_ready(rd_ready),
    .rd_value(rd_value), .arf_we(arf_we), .arf_addr(arf_addr), .arf_data(arf_data),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (arf_we && nlog < 64) begin
        log_addr[nlog] = arf_addr;
        log_data[nlog] = arf_data;
        nlog++;
      end
      if (redirect_valid) begin
        nred++;
        last_tgt = redirect_target;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic alloc(input logic br, input logic [4:0] dest, input logic [2:0] exp_tag);
    alloc_valid = 1'b1; alloc_is_branch = br; alloc_dest = dest;
    #1;
    chk("R2", "alloc_ready", alloc_ready, 1);
    chk("R2", "alloc_tag", alloc_tag, exp_tag);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] tag, input logic [31:0] val, input logic mis);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val; cdb_mispredict = mis;
    tick();
    cdb_valid = 1'b0; cdb_mispredict = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic t_reset();
    rd_tag = {3'd5, 3'd0};
    #1;
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "arf_we", arf_we, 0);
    chk("R1", "redirect_valid", redirect_valid, 0);
    chk("R1", "rd_ready", rd_ready, 0);
  endtask

  task automatic t_out_of_order();
    alloc(1'b0, 5'd5, 3'd0);
    alloc(1'b0, 5'd6, 3'd1);
    alloc(1'b0, 5'd7, 3'd2);
    rd_tag = {3'd2, 3'd1};
    #1;
    chk("R11", "pending rd_ready", rd_ready, 2'b00);
    bcast(3'd2, 32'h22, 1'b0);
    bcast(3'd1, 32'h11, 1'b0);
    idle(2);
    chk("R5", "no early retire", nlog, 0);
    rd_tag = {3'd1, 3'd2};
    #1;
    chk("R4", "rd_ready both", rd_ready, 2'b11);
    chk("R4", "port0 value", rd_value[31:0], 32'h22);
    chk("R4", "port1 value", rd_value[63:32], 32'h11);
    bcast(3'd0, 32'h10, 1'b0);
    chk("R6", "no write on capture edge", arf_we, 0);
    tick();
    chk("R6", "we0", arf_we, 1);
    chk("R6", "addr0", arf_addr, 5);
    chk("R6", "data0", arf_data, 32'h10);
    tick();
    chk("R5", "addr1", arf_addr, 6);
    chk("R5", "data1", arf_data, 32'h11);
    tick();
    chk("R5", "addr2", arf_addr, 7);
    chk("R5", "data2", arf_data, 32'h22);
    tick();
    chk("R6", "we idle", arf_we, 0);
    chk("R5", "write count", nlog, 3);
  endtask

  task automatic t_good_branch();
    int base = nlog;
    alloc(1'b1, 5'd0, 3'd3);
    bcast(3'd3, 32'h100, 1'b0);
    idle(3);
    chk("R7", "no write", nlog, base);
    chk("R7", "no redirect", nred, 0);
    #1;
    chk("R7", "entry freed tag", alloc_tag, 4);
    chk("R7", "entry freed ready", alloc_ready, 1);
  endtask

  task automatic t_alloc_with_retire();
    int base = nlog;
    alloc(1'b0, 5'd9, 3'd4);
    bcast(3'd4, 32'h44, 1'b0);
    alloc(1'b0, 5'd10, 3'd5);
    chk("R9", "retire same cycle we", arf_we, 1);
    chk("R9", "retire same cycle addr", arf_addr, 9);
    bcast(3'd5, 32'h55, 1'b0);
    idle(2);
    chk("R9", "writes", nlog, base + 2);
    chk("R9", "second addr", log_addr[base + 1], 10);
    chk("R9", "second data", log_data[base + 1], 32'h55);
    #1;
    chk("R9", "next tag", alloc_tag, 6);
  endtask

  task automatic t_full_wrap();
    int base = nlog;
    for (int i = 0; i < 8; i++) alloc(1'b0, 5'(i + 1), 3'((6 + i) % 8));
    #1;
    chk("R3", "full not ready", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_dest = 5'd31;
    tick();
    alloc_valid = 1'b0;
    chk("R3", "still full", alloc_ready, 0);
    for (int i = 0; i < 8; i++) bcast(3'((6 + i) % 8), 32'h500 + 32'(i), 1'b0);
    idle(3);
    chk("R3", "write count", nlog, base + 8);
    for (int i = 0; i < 8; i++) begin
      chk("R2", "wrap order addr", log_addr[base + i], 64'(i + 1));
      chk("R2", "wrap order data", log_data[base + i], 64'(32'h500 + 32'(i)));
    end
    #1;
    chk("R3", "tail unmoved", alloc_tag, 6);
    chk("R3", "ready again", alloc_ready, 1);
  endtask

  task automatic t_mispredict();
    int base = nlog;
    alloc(1'b0, 5'd3, 3'd6);
    alloc(1'b1, 5'd0, 3'd7);
    alloc(1'b0, 5'd4, 3'd0);
    bcast(3'd0, 32'h40, 1'b0);
    bcast(3'd7, 32'h2000, 1'b1);
    idle(2);
    chk("R5", "head pending blocks", nlog, base);
    bcast(3'd6, 32'h66, 1'b0);
    tick();
    chk("R8", "older op writes", arf_we, 1);
    chk("R8", "older op addr", arf_addr, 3);
    tick();
    chk("R8", "redirect", redirect_valid, 1);
    chk("R8", "target", redirect_target, 32'h2000);
    chk("R8", "no write with redirect", arf_we, 0);
    tick();
    chk("R8", "pulse ends", redirect_valid, 0);
    rd_tag = {3'd7, 3'd0};
    #1;
    chk("R8", "tag after flush", alloc_tag, 0);
    chk("R8", "ready after flush", alloc_ready, 1);
    chk("R8", "flushed entries", rd_ready, 2'b00);
    idle(3);
    chk("R8", "younger never retires", nlog, base + 1);
    chk("R8", "one redirect", nred, 1);
  endtask

  task automatic t_idle_write();
    int base = nlog;
    bcast(3'd0, 32'h77, 1'b0);
    alloc(1'b0, 5'd12, 3'd0);
    rd_tag = {3'd0, 3'd0};
    #1;
    chk("R10", "stale result ignored", rd_ready, 2'b00);
    idle(3);
    chk("R10", "no retire", nlog, base);
    bcast(3'd0, 32'h78, 1'b0);
    idle(2);
    chk("R10", "retire count", nlog, base + 1);
    chk("R10", "retired value", log_data[base], 32'h78);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_out_of_order();
    t_good_branch();
    t_alloc_with_retire();
    t_full_wrap();
    t_mispredict();
    t_idle_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule